// File: doc/BRIEF.md
# I2C Register Bank Slave

This block is a synthesizable I2C target that gives a host on a two-wire serial bus access to a small array of byte-wide registers. The serial clock and data lines are brought into a faster system clock domain through two-flop synchronizers. Bus events are then recognised on the synchronized copies: START, repeated START, STOP, and the rising and falling edges of the serial clock. The block pulls the data line low through a single output enable and never drives it high. Outside the block, the pad is wired as open drain.

A write transfer is made of three parts. The controller first sends the device address with the direction bit clear. The next byte selects a register index. Any further bytes are stored starting at that index. A read transfer is made of the device address with the direction bit set. It returns register contents beginning at the current index. In both directions the index steps forward once per byte and wraps at the end of the array. A transfer can run for any number of bytes, and a repeated START lets a controller set the index with a write and then read from it without releasing the bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A START or repeated START, seen as SDA falling while SCL is high, restarts address reception from bit 0 in any state, including in the middle of a byte.
- R2: A STOP, seen as SDA rising while SCL is high, returns the block to idle with SDA released. The register index and the register contents survive a STOP.
- R3: Each byte takes nine SCL pulses, sent MSB first. When the 7-bit address in bits 7:1 of the first byte equals `DEV_ADDR` (default 7'b1101000), the block holds SDA low for the whole high phase of the ninth pulse. Bit 0 selects the direction: 0 is write and 1 is read.
- R4: When the address does not match, the block gives no acknowledge, keeps SDA released for every following bit, and changes no register until the next START or STOP.
- R5: In a write transfer, the first byte after the address loads the register index from its low log2(NREG) bits, and that byte is acknowledged.
- R6: Every later byte of a write transfer is acknowledged and stored at the index. The index then increments and wraps from NREG-1 to 0, so a burst longer than NREG overwrites the earliest entries.
- R7: In a read transfer, after acknowledging its address, the block shifts out the register at the index, MSB first. The index increments once per byte sent, wrapping from NREG-1 to 0. A controller ACK (SDA low on the ninth pulse) starts the next byte.
- R8: After a controller NACK on a read byte, the block leaves SDA released until the next START or STOP.
- R9: The SDA output enable changes only while SCL is low. It is asserted after the SCL falling edge that begins an ACK or data bit and released after the falling edge that ends it.
- R10: After reset, SDA is released, the index is 0, and every register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus (asynchronous) |
| sda_i | input | 1 | Serial data as seen on the bus (asynchronous) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |

## Verification
The bench builds the block with NREG = 4 and the default address, keeping the index space small enough to sweep. It writes from every start index with bursts of six bytes, so each burst wraps the index, and it reads each burst back from the same index. All 128 address values are offered with the write bit, which shows that exactly one of them is acknowledged. The small array also lets one foreign-address write and one repeated-START hand-over be checked against a complete register model.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1101000,
  parameter int         NREG     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_PTR, S_WR, S_RD, S_SKIP} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           st;
  logic [3:0]    bcnt;
  logic          in_ack, rd_mode, m_ack;
  logic [7:0]    sh;
  logic [PW-1:0] ptr;
  logic [7:0]    mem [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire byte_done = (bcnt == 4'd8);
  wire receiving = (st == S_ADDR) || (st == S_PTR) || (st == S_WR);

  wire [PW-1:0] ptr_nx = (ptr == PW'(NREG - 1)) ? '0 : ptr + 1'b1;
  wire [7:0]    rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      in_ack  <= 1'b0;
      rd_mode <= 1'b0;
      m_ack   <= 1'b0;
      sh      <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (start_det) begin
      st     <= S_ADDR;
      bcnt   <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      bcnt   <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (receiving) begin
      if (scl_rise && !in_ack && !byte_done) begin
        sh   <= {sh[6:0], sda_s};
        bcnt <= bcnt + 1'b1;
      end else if (scl_fall && !in_ack && byte_done) begin
        in_ack <= 1'b1;
        if (st == S_ADDR) begin
          if (sh[7:1] == DEV_ADDR) begin
            sda_oe  <= 1'b1;
            rd_mode <= sh[0];
          end else begin
            st <= S_SKIP;
          end
        end else if (st == S_PTR) begin
          sda_oe <= 1'b1;
          ptr    <= sh[PW-1:0];
        end else begin
          sda_oe   <= 1'b1;
          mem[ptr] <= sh;
          ptr      <= ptr_nx;
        end
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        bcnt   <= '0;
        sda_oe <= 1'b0;
        if (st == S_ADDR) begin
          if (rd_mode) begin
            st     <= S_RD;
            sh     <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end else begin
            st <= S_PTR;
          end
        end else if (st == S_PTR) begin
          st <= S_WR;
        end
      end
    end else if (st == S_RD) begin
      if (scl_rise && !in_ack && !byte_done) begin
        bcnt <= bcnt + 1'b1;
      end else if (scl_rise && in_ack) begin
        m_ack <= ~sda_s;
      end else if (scl_fall && !in_ack && !byte_done && bcnt != 4'd0) begin
        sh     <= {sh[6:0], 1'b0};
        sda_oe <= ~sh[6];
      end else if (scl_fall && !in_ack && byte_done) begin
        sda_oe <= 1'b0;
        in_ack <= 1'b1;
        ptr    <= ptr_nx;
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        bcnt   <= '0;
        if (m_ack) begin
          sh     <= rd_byte;
          sda_oe <= ~rd_byte[7];
        end else begin
          st <= S_SKIP;
        end
      end
    end

  AST_OE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !scl_s);                              // R9
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR && bcnt == 4'd0 && !in_ack));           // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe));                            // R2
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP) |-> !sda_oe);                                        // R4
  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && in_ack) |-> !sda_oe);                                // R8
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd8);                                                      // R3
endmodule

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
  localparam int NR = 4;
  localparam int Q  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda;
  assign sda = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regbank_slave #(.DEV_ADDR(7'b1101000), .NREG(NR)) u_i2c_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [NR];

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2 * Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = ~sda;   tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda; tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = ~give_ack; tick(Q);
    scl = 1'b1;        tick(2 * Q);
    scl = 1'b0;        tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int sp, input int i);
    return 8'((sp * 37 + i * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    logic ack;
    logic [7:0] b;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    tick(5);
    check(sda_oe == 1'b0, "R10 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R10 oe after reset", int'(sda_oe), 0);

    i2c_start();
    put_byte(8'hD1, ack);
    check(ack, "R3 read address ack", int'(ack), 1);
    for (int i = 0; i < NR; i++) begin
      get_byte(i != NR - 1, b);
      check(b == 8'h00, "R10 reset register value", int'(b), 0);
    end
    i2c_stop();

    for (int a = 0; a < 128; a++) begin
      i2c_start();
      put_byte({7'(a), 1'b0}, ack);
      check(ack == (a == 7'h68), "R3 R4 address sweep", int'(ack), int'(a == 7'h68));
      i2c_stop();
    end
    check(sda_oe == 1'b0, "R2 released after stop", int'(sda_oe), 0);

    for (int sp = 0; sp < NR; sp++) begin
      i2c_start();
      put_byte(8'hD0, ack);
      check(ack, "R3 write address ack", int'(ack), 1);
      put_byte(8'hA0 | 8'(sp), ack);
      check(ack, "R5 index byte ack", int'(ack), 1);
      for (int i = 0; i < 6; i++) begin
        put_byte(pat(sp, i), ack);
        check(ack, "R6 data byte ack", int'(ack), 1);
        model[(sp + i) % NR] = pat(sp, i);
      end
      i2c_stop();

      i2c_start();
      put_byte(8'hD0, ack);
      put_byte(8'(sp), ack);
      i2c_start();
      put_byte(8'hD1, ack);
      check(ack, "R1 repeated start address ack", int'(ack), 1);
      for (int i = 0; i < 6; i++) begin
        get_byte(i != 5, b);
        check(b == model[(sp + i) % NR], "R7 read burst with wrap", int'(b), int'(model[(sp + i) % NR]));
      end
      get_byte(1'b0, b);
      check(b == 8'hFF, "R8 released after nack", int'(b), 8'hFF);
      i2c_stop();
    end

    i2c_start();
    put_byte(8'hD1, ack);
    get_byte(1'b0, b);
    check(b == model[(NR - 1 + 6) % NR], "R7 index continues after read", int'(b), int'(model[(NR - 1 + 6) % NR]));
    i2c_stop();

    i2c_start();
    put_byte(8'hD2, ack);
    check(!ack, "R4 foreign address nack", int'(ack), 0);
    put_byte(8'h00, ack);
    check(!ack, "R4 foreign index ignored", int'(ack), 0);
    put_byte(8'h55, ack);
    check(!ack, "R4 foreign data ignored", int'(ack), 0);
    i2c_stop();
    i2c_start();
    put_byte(8'hD0, ack);
    put_byte(8'h00, ack);
    i2c_start();
    put_byte(8'hD1, ack);
    for (int i = 0; i < NR; i++) begin
      get_byte(i != NR - 1, b);
      check(b == model[i], "R4 registers unchanged", int'(b), int'(model[i]));
    end
    i2c_stop();

    i2c_start();
    put_byte(8'hD0, ack);
    put_byte(8'h01, ack);
    put_byte(8'h3C, ack);
    model[1] = 8'h3C;
    i2c_start();
    put_byte(8'hD1, ack);
    check(ack, "R1 restart mid write", int'(ack), 1);
    get_byte(1'b0, b);
    check(b == model[2], "R6 index advanced by write", int'(b), int'(model[2]));
    i2c_stop();

    i2c_start();
    put_byte(8'hD0, ack);
    put_byte(8'h03, ack);
    i2c_stop();
    check(sda_oe == 1'b0, "R2 stop releases line", int'(sda_oe), 0);
    i2c_start();
    put_byte(8'hD1, ack);
    get_byte(1'b0, b);
    check(b == model[3], "R2 index kept across stop", int'(b), int'(model[3]));
    i2c_stop();

    i2c_start();
    put_byte(8'hD0, ack);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
    put_byte(8'hD1, ack);
    check(ack, "R1 restart inside index byte", int'(ack), 1);
    get_byte(1'b0, b);
    check(b == model[0], "R1 read after early restart", int'(b), int'(model[0]));
    i2c_stop();

    check(oe_viol == 0, "R9 enable changes only with SCL low", oe_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule